// File: doc/BRIEF.md
# Programmable External Bus Chip-Select Unit

The unit turns external bus addresses into six active-low select strobes. Each strobe has its own address window, defined by three registers: a base address, an address mask that carries an enable bit, and a control word that holds a wait-state count. Writes reach these registers through a single-cycle write port. When an access starts, the unit compares the upper sixteen address bits against every enabled window. It drives the matching strobe low for one base cycle plus the programmed wait states, and then pulses a transfer-done output for one cycle. An access that matches no window raises a one-cycle error flag instead.

Strobe 0 serves as the boot select. From reset until its own enable bit is set, strobe 0 fires on every access at any address, and strobes 1 to 5 are held off, even when their own windows are already enabled. While reset is held, the unit samples a two-bit boot port-size setting from input pins and keeps that value afterwards.

Top module: `ebcs_unit`

## Requirements
- R1: At most one of the six `cs_n_o` outputs is low at any time.
- R2: Reset clears every window's enable bit, holds all `cs_n_o` high and keeps `xfer_ack_o` and `acc_err_o` low. `boot_size_o` takes the value of `cfg_size_i` sampled while `rst_n` is low and keeps it after reset is released.
- R3: While the enable bit of window 0 is clear, every accepted access drives `cs_n_o[0]` low, whatever the address. The timing uses window 0's wait count, which resets to 3.
- R4: While the enable bit of window 0 is clear, `cs_n_o[5:1]` never go low, even for windows whose own enable bit is set.
- R5: A window matches when `((addr[31:16] ^ base[31:16]) & ~mask[31:16]) == 0`. The base is register bits 31:16, the mask is register bits 31:16 (a 1 ignores that address bit), and the enable bit is mask register bit 0. Examples: mask 0x00FF_0001 gives a 16 MB window and 0x0003_0001 gives a 256 KB window.
- R6: When several enabled windows match, only the lowest-numbered one is driven low.
- R7: The wait count is control register bits 15:10, so 0x17A0, 0x1BA0 and 0x0BA0 give 5, 6 and 2. The selected strobe goes low in the cycle after the accepting clock edge and stays low for wait+1 cycles.
- R8: `xfer_ack_o` is high for exactly one cycle, the first cycle after the strobe returns high.
- R9: Once window 0 is enabled, an access that matches no enabled window drives no strobe and no acknowledge, and `acc_err_o` is high for one cycle, the cycle after the accepting edge.
- R10: `acc_start_i` is ignored while `busy_o` is high. Such a start produces no error and no later access.
- R11: A register write in the same cycle as an accepted start has no effect on that access. The access is decoded with the register values from before the write.
- R12: `reg_kind_i` selects 0 = base, 1 = mask, 2 = control. Kind 3 and window indices 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_size_i | input | 2 | Boot port-size setting, sampled during reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_win_i | input | 3 | Window index of the write |
| reg_kind_i | input | 2 | Register kind: 0 base, 1 mask, 2 control |
| reg_data_i | input | 32 | Write data |
| acc_start_i | input | 1 | Start of an external access |
| acc_addr_i | input | 32 | Access address, valid with the start |
| cs_n_o | output | 6 | Active-low chip-selects |
| xfer_ack_o | output | 1 | One-cycle transfer-done pulse |
| acc_err_o | output | 1 | One-cycle no-match error pulse |
| busy_o | output | 1 | An access is in progress |
| boot_size_o | output | 2 | Latched boot port size |

## Verification
Two functions can fall in the same cycle: a register write, and the decode of an access that starts in that cycle. The bench sets the enable bit of window 0 in the same cycle as a start whose address lies inside window 1. It expects that access to still go out on strobe 0 in global mode, with window 0's wait count, and it expects the next access to the same address to select strobe 1. A second overlap, a start that arrives while an access is already running, is provoked in the middle of a strobe. The bench judges it by the absence of any error pulse and of any extra strobe after the acknowledge.

// File: rtl/ebcs_pkg.sv
package ebcs_pkg;
  localparam int HI_W   = 16;
  localparam int WAIT_W = 6;

  typedef enum logic [1:0] {
    K_BASE = 2'd0,
    K_MASK = 2'd1,
    K_CTRL = 2'd2,
    K_NONE = 2'd3
  } reg_kind_e;

  // window compare on upper address half; mask bit set = don't care
  function automatic logic win_match(input logic [HI_W-1:0] a_hi,
                                     input logic [HI_W-1:0] base_hi,
                                     input logic [HI_W-1:0] mask_hi);
    return ((a_hi ^ base_hi) & ~mask_hi) == '0;
  endfunction

  // wait-state field of the control word
  function automatic logic [WAIT_W-1:0] ctl_wait(input logic [31:0] d);
    return d[15:10];
  endfunction
endpackage

// File: rtl/ebcs_regs.sv
module ebcs_regs
  import ebcs_pkg::*;
#(
  parameter int N_WIN     = 6,
  parameter int IDX_W     = 3,
  parameter int BOOT_WAIT = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             win,
  input  logic [1:0]                   kind,
  input  logic [31:0]                  data,
  output logic [N_WIN-1:0][HI_W-1:0]   base_q,
  output logic [N_WIN-1:0][HI_W-1:0]   mask_q,
  output logic [N_WIN-1:0]             valid_q,
  output logic [N_WIN-1:0][WAIT_W-1:0] wait_q
);
  logic win_ok;
  assign win_ok = (int'(win) < N_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      mask_q    <= '0;
      valid_q   <= '0;
      wait_q    <= '0;
      wait_q[0] <= WAIT_W'(BOOT_WAIT);
    end else if (we && win_ok) begin
      case (reg_kind_e'(kind))
        K_BASE: base_q[win] <= data[31:16];
        K_MASK: begin
          mask_q[win]  <= data[31:16];
          valid_q[win] <= data[0];
        end
        K_CTRL: wait_q[win] <= ctl_wait(data);
        default: ;
      endcase
    end
  end

  // R12: out-of-range window index never touches stored state
  a_r12_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !win_ok) |=> ($stable(valid_q) && $stable(base_q) && $stable(mask_q) && $stable(wait_q)));
endmodule

// File: rtl/ebcs_decode.sv
module ebcs_decode
  import ebcs_pkg::*;
#(
  parameter int N_WIN = 6
) (
  input  logic [31:0]                  addr,
  input  logic [N_WIN-1:0][HI_W-1:0]   base_q,
  input  logic [N_WIN-1:0][HI_W-1:0]   mask_q,
  input  logic [N_WIN-1:0]             valid_q,
  input  logic [N_WIN-1:0][WAIT_W-1:0] wait_q,
  output logic                         glob,
  output logic [N_WIN-1:0]             sel,
  output logic                         miss,
  output logic [WAIT_W-1:0]            wait_sel
);
  logic [N_WIN-1:0] hit;

  assign glob = !valid_q[0];

  generate
    for (genvar i = 0; i < N_WIN; i++) begin : g_win
      if (i == 0) begin : g_boot
        assign hit[i] = glob || win_match(addr[31:16], base_q[i], mask_q[i]);
      end else begin : g_norm
        assign hit[i] = !glob && valid_q[i] && win_match(addr[31:16], base_q[i], mask_q[i]);
      end
    end
  endgenerate

  always_comb begin
    logic found;
    found    = 1'b0;
    sel      = '0;
    wait_sel = '0;
    for (int i = 0; i < N_WIN; i++) begin
      if (hit[i] && !found) begin
        sel[i]   = 1'b1;
        wait_sel = wait_q[i];
        found    = 1'b1;
      end
    end
    miss = !found;
  end
endmodule

// File: rtl/ebcs_timer.sv
module ebcs_timer
  import ebcs_pkg::*;
#(
  parameter int N_WIN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_WIN-1:0]  sel,
  input  logic              miss,
  input  logic [WAIT_W-1:0] wait_sel,
  output logic              go,
  output logic [N_WIN-1:0]  cs_n,
  output logic              ack,
  output logic              err,
  output logic              busy
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ACK} st_e;
  st_e               st;
  logic [WAIT_W-1:0] cnt;

  assign busy = (st != S_IDLE);
  assign go   = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      cs_n <= '1;
      ack  <= 1'b0;
      err  <= 1'b0;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          if (miss) err <= 1'b1;
          else begin
            cs_n <= ~sel;
            cnt  <= wait_sel;
            st   <= S_RUN;
          end
        end
        S_RUN: if (cnt == '0) begin
          cs_n <= '1;
          ack  <= 1'b1;
          st   <= S_ACK;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && cnt != '0) |=> $stable(cs_n));
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r8_ack_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(cs_n) != '1 && cs_n == '1));
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n == '1 && !ack));
  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err);
endmodule

// File: rtl/ebcs_unit.sv
module ebcs_unit
  import ebcs_pkg::*;
#(
  parameter int N_WIN     = 6,
  parameter int BOOT_WAIT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_size_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_win_i,
  input  logic [1:0]  reg_kind_i,
  input  logic [31:0] reg_data_i,
  input  logic        acc_start_i,
  input  logic [31:0] acc_addr_i,
  output logic [5:0]  cs_n_o,
  output logic        xfer_ack_o,
  output logic        acc_err_o,
  output logic        busy_o,
  output logic [1:0]  boot_size_o
);
  localparam int IDX_W = 3;

  logic [N_WIN-1:0][HI_W-1:0]   base_q, mask_q;
  logic [N_WIN-1:0]             valid_q;
  logic [N_WIN-1:0][WAIT_W-1:0] wait_q;
  logic                         glob, miss, acc_go;
  logic [N_WIN-1:0]             sel, cs_n;
  logic [WAIT_W-1:0]            wait_sel;
  logic [1:0]                   boot_q;

  ebcs_regs #(.N_WIN(N_WIN), .IDX_W(IDX_W), .BOOT_WAIT(BOOT_WAIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .win(reg_win_i),
    .kind(reg_kind_i), .data(reg_data_i),
    .base_q(base_q), .mask_q(mask_q), .valid_q(valid_q), .wait_q(wait_q));

  ebcs_decode #(.N_WIN(N_WIN)) u_dec (
    .addr(acc_addr_i), .base_q(base_q), .mask_q(mask_q), .valid_q(valid_q),
    .wait_q(wait_q), .glob(glob), .sel(sel), .miss(miss), .wait_sel(wait_sel));

  ebcs_timer #(.N_WIN(N_WIN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(acc_start_i), .sel(sel), .miss(miss),
    .wait_sel(wait_sel), .go(acc_go), .cs_n(cs_n), .ack(xfer_ack_o),
    .err(acc_err_o), .busy(busy_o));

  // boot port size follows the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= cfg_size_i;
  end

  assign cs_n_o      = cs_n;
  assign boot_size_o = boot_q;

  a_r3_global_cs0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && glob) |=> !cs_n_o[0]);
  a_r4_others_held: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && glob) |=> (&cs_n_o[5:1]));
  a_r9_no_err_global: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && glob) |=> !acc_err_o);
  a_r2_boot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_size_o));
endmodule

// File: tb/sim_ebcs_unit.sv
module sim_ebcs_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_size_i = 2'b10;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_win_i = '0;
  logic [1:0]  reg_kind_i = '0;
  logic [31:0] reg_data_i = '0;
  logic        acc_start_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [5:0]  cs_n_o;
  logic        xfer_ack_o, acc_err_o, busy_o;
  logic [1:0]  boot_size_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ebcs_unit u0 (.*);

  localparam int MISS = 15;
  // {address, expected window (15 = miss), expected wait}
  localparam logic [41:0] VEC [9] = '{
    {32'h0000_0000, 4'd0, 6'd5},
    {32'h00FF_FFFC, 4'd0, 6'd5},
    {32'h0100_0000, 4'd15, 6'd0},
    {32'h1000_0000, 4'd1, 6'd6},
    {32'h1003_FFFC, 4'd1, 6'd6},
    {32'h1004_0000, 4'd15, 6'd0},
    {32'h200D_0000, 4'd2, 6'd2},
    {32'h20FF_0000, 4'd2, 6'd2},
    {32'h3000_0000, 4'd15, 6'd0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int w, input int k, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_win_i = 3'(w); reg_kind_i = 2'(k); reg_data_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic start_acc(input logic [31:0] a);
    @(negedge clk);
    acc_start_i = 1'b1; acc_addr_i = a;
    @(negedge clk);
    acc_start_i = 1'b0;
  endtask

  // called at the first negedge after the accepting edge
  task automatic expect_acc(input int idx, input int w, input string req);
    if (idx == MISS) begin
      check(acc_err_o && cs_n_o == 6'h3F, req, {25'd0, acc_err_o, cs_n_o}, {25'd0, 1'b1, 6'h3F});
      @(negedge clk);
      check(!acc_err_o && !xfer_ack_o, req, {30'd0, acc_err_o, xfer_ack_o}, 32'd0);
    end else begin
      logic [5:0] exp_cs;
      exp_cs = 6'h3F & ~(6'd1 << idx);
      for (int k = 0; k <= w; k++) begin
        check(cs_n_o == exp_cs && !xfer_ack_o, req, {25'd0, xfer_ack_o, cs_n_o}, {26'd0, exp_cs});
        @(negedge clk);
      end
      check(cs_n_o == 6'h3F && xfer_ack_o, req, {25'd0, xfer_ack_o, cs_n_o}, {25'd0, 1'b1, 6'h3F});
      @(negedge clk);
      check(!xfer_ack_o, req, {31'd0, xfer_ack_o}, 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_size_i = 2'b01;
    // R2 reset state
    check(cs_n_o == 6'h3F && !xfer_ack_o && !acc_err_o && !busy_o, "R2 idle after reset",
          {24'd0, busy_o, xfer_ack_o, acc_err_o, cs_n_o}, {26'd0, 6'h3F});
    @(negedge clk);
    check(boot_size_o == 2'b10, "R2 boot size latched", {30'd0, boot_size_o}, 32'd2);

    // program windows 1 and 2 (enabled) while window 0 is still off
    wr(1, 0, 32'h1000_0000); wr(1, 1, 32'h0003_0001); wr(1, 2, 32'h0000_1BA0);
    wr(2, 0, 32'h2000_0000); wr(2, 1, 32'h00FF_0001); wr(2, 2, 32'h0000_0BA0);
    // R3 R4 global mode: cs0 everywhere, reset wait 3
    start_acc(32'h1000_0000); expect_acc(0, 3, "R3 R4 global at window1 address");
    start_acc(32'h200D_0000); expect_acc(0, 3, "R3 R4 global at window2 address");
    start_acc(32'h7777_0000); expect_acc(0, 3, "R3 global at unmapped address");

    wr(0, 0, 32'h0000_0000); wr(0, 2, 32'h0000_17A0);
    // R11 enable window 0 in the same cycle as a start
    @(negedge clk);
    reg_we_i = 1'b1; reg_win_i = 3'd0; reg_kind_i = 2'd1; reg_data_i = 32'h00FF_0001;
    acc_start_i = 1'b1; acc_addr_i = 32'h1000_0000;
    @(negedge clk);
    reg_we_i = 1'b0; acc_start_i = 1'b0;
    expect_acc(0, 5, "R11 write same cycle as start uses old state");
    start_acc(32'h1000_0000); expect_acc(1, 6, "R11 new state on next access");

    // table walk: R5 R7 R8 R9
    for (int i = 0; i < 9; i++) begin
      start_acc(VEC[i][41:10]);
      expect_acc(int'(VEC[i][9:6]), int'(VEC[i][5:0]), "R5 R7 R8 R9 table");
    end

    // R6 priority: window 3 overlaps window 1, wait 1
    wr(3, 0, 32'h1000_0000); wr(3, 1, 32'h00FF_0001); wr(3, 2, 32'h0000_0400);
    start_acc(32'h1000_0000); expect_acc(1, 6, "R6 lowest index wins");
    start_acc(32'h1080_0000); expect_acc(3, 1, "R6 only window3 matches");

    // R10 start while busy is ignored
    start_acc(32'h1000_0000);
    check(cs_n_o == 6'h3D, "R10 access running", {26'd0, cs_n_o}, 32'h3D);
    acc_start_i = 1'b1; acc_addr_i = 32'h3000_0000;
    @(negedge clk);
    acc_start_i = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      check(cs_n_o == 6'h3D && !acc_err_o, "R10 busy start ignored", {25'd0, acc_err_o, cs_n_o}, 32'h3D);
      @(negedge clk);
    end
    check(xfer_ack_o && cs_n_o == 6'h3F, "R10 R8 ack", {25'd0, xfer_ack_o, cs_n_o}, 32'h7F);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(cs_n_o == 6'h3F && !acc_err_o && !xfer_ack_o, "R10 no late access",
            {24'd0, xfer_ack_o, acc_err_o, cs_n_o}, 32'h3F);
    end

    // R12 ignored kind and out-of-range windows
    wr(1, 3, 32'hFFFF_FFFF);
    wr(6, 1, 32'h0000_0000);
    wr(7, 2, 32'h0000_FC00);
    start_acc(32'h1000_0000); expect_acc(1, 6, "R12 ignored writes leave window1");
    start_acc(32'h0000_0000); expect_acc(0, 5, "R12 ignored writes leave window0");

    check(boot_size_o == 2'b10, "R2 boot size held", {30'd0, boot_size_o}, 32'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule